// File: doc/BRIEF.md
# PLL Lock Status and Reset Controller

This block keeps the two lock flags that software reads for a phase-locked loop: `lock_o`, which follows the loop's present lock state, and `locks_o`, which tells whether the most recent loss of lock was intended (a multiplier change, or the PLL switched off on purpose in stop mode) or unexpected. It takes single-cycle lock and unlock events from an external lock detector and pulses that mark a multiplier change and stop-mode entry and exit. Write-enable inputs stand in for the register interface.

It also owns the loss-of-lock reset. While the enable bit is set, a loss of lock raises a reset request. The request clears the lock flags and the enable bit. A sticky cause bit, which the request does not touch, records that loss of lock caused the reset. The request is held for a fixed minimum number of cycles. In PLL mode it then stays up until the reference is present and lock has come back. The same sequence runs after power-on reset.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After any reset (power-on or loss-of-lock request), the first `lock_evt_i` sets both `lock_o` and `locks_o` in the next cycle. `locks_o` is never 1 while `lock_o` is 0. A `lock_evt_i` while `lock_o` is already 1 changes nothing.
- R2: `mult_chg_i` clears `lock_o` and `locks_o` in the next cycle. The next relock sets both. An `unlock_evt_i` that arrives while `lock_o` is already 0 is ignored and does not affect this.
- R3: An `unlock_evt_i` while `lock_o` is 1 (unexpected loss) clears both flags. The next relock sets `lock_o` only, and `locks_o` stays 0.
- R4: A `stop_enter_i` pulse with `stop_pll_off_i` high clears both flags and causes lock events to be ignored until `stop_exit_i`. The next relock after that sets `lock_o` and restores `locks_o` to the value it had at entry. A stop entry with `stop_pll_off_i` low, and a stop exit outside stop-off, change nothing.
- R5: A loss of lock under R2 or R3 raises `rst_req_o` in the next cycle when the enable bit is 1. Nothing happens when the enable bit is 0. The enable bit is loaded from `lol_en_i` when `lol_en_we_i` is high.
- R6: While the request holds, `lock_o`, `locks_o` and the enable bit are cleared, and lock events are ignored.
- R7: `lol_flag_o` becomes 1 in the cycle a loss-of-lock request starts. It survives that request. Only power-on reset (`rst_ni` low) or a `lol_clr_i` pulse clears it.
- R8: `rst_req_o` is 1 right after power-on reset and right after a loss-of-lock trigger, and it stays 1 for at least `HOLD_CYC` (default 16) cycles.
- R9: After the hold, with `pll_mode_i` high, `rst_req_o` falls one cycle after `ref_ok_i` and `lock_o` are both 1. With `pll_mode_i` low it falls in the cycle after the hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| pll_mode_i | input | 1 | Clocks come from the PLL; release needs lock |
| ref_ok_i | input | 1 | Reference clock present |
| lock_evt_i | input | 1 | Detector pulse: lock acquired |
| unlock_evt_i | input | 1 | Detector pulse: lock lost |
| mult_chg_i | input | 1 | Pulse: multiplication factor written |
| stop_enter_i | input | 1 | Pulse: stop mode entered |
| stop_exit_i | input | 1 | Pulse: stop mode left |
| stop_pll_off_i | input | 1 | PLL is switched off during stop |
| lol_en_we_i | input | 1 | Write strobe for the loss-of-lock reset enable |
| lol_en_i | input | 1 | Write data for the enable |
| lol_clr_i | input | 1 | Write-one-to-clear of the sticky cause bit |
| lock_o | output | 1 | Present lock flag |
| locks_o | output | 1 | Sticky lock flag (last loss was intended) |
| rst_req_o | output | 1 | Reset request to the system |
| lol_flag_o | output | 1 | Reset was caused by loss of lock |

## Verification
The assertions assume that event inputs are single-cycle pulses from one source: an unlock and a lock event never arrive together, and stop entry and exit never coincide. The assertions also take `pll_mode_i` to be steady while a request is in its hold phase. The stimulus drives every pulse for exactly one cycle on the falling edge, sends one event per cycle, and changes `pll_mode_i` and `ref_ok_i` only when no request is active or during the wait phase. The bench samples the outputs on the falling edge after each event.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HOLD = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/plc_flags.sv
module plc_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic lock_evt_i,
  input  logic unlock_evt_i,
  input  logic mult_chg_i,
  input  logic stop_enter_i,
  input  logic stop_exit_i,
  input  logic stop_pll_off_i,
  output logic lock_o,
  output logic locks_o,
  output logic loss_o
);
  logic lock_q, locks_q, pend_q, off_q;
  logic enter_off;

  assign enter_off = stop_enter_i & stop_pll_off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      locks_q <= 1'b0;
      pend_q  <= 1'b1;
      off_q   <= 1'b0;
    end else if (hold_i) begin
      lock_q  <= 1'b0;
      locks_q <= 1'b0;
      pend_q  <= 1'b1;
      off_q   <= 1'b0;
    end else if (off_q) begin
      if (stop_exit_i) off_q <= 1'b0;
    end else if (enter_off) begin
      off_q   <= 1'b1;
      lock_q  <= 1'b0;
      locks_q <= 1'b0;
      // keep pending value if not locked at entry
      if (lock_q) pend_q <= locks_q;
    end else if (mult_chg_i) begin
      lock_q  <= 1'b0;
      locks_q <= 1'b0;
      pend_q  <= 1'b1;
    end else if (unlock_evt_i && lock_q) begin
      lock_q  <= 1'b0;
      locks_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (lock_evt_i && !lock_q) begin
      lock_q  <= 1'b1;
      locks_q <= pend_q;
    end
  end

  assign loss_o  = lock_q & ~off_q & ~enter_off & (mult_chg_i | unlock_evt_i);
  assign lock_o  = lock_q;
  assign locks_o = locks_q;

  assert_locks_needs_lock_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locks_q |-> lock_q);
  assert_mfd_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_chg_i |=> !lock_q && !locks_q);
  assert_unexp_loss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_evt_i && lock_q && !mult_chg_i && !stop_enter_i && !hold_i) |=> !lock_q && !locks_q);
  assert_stop_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> !lock_q);
  assert_hold_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !lock_q && !locks_q);
endmodule

// File: rtl/plc_rst_seq.sv
module plc_rst_seq #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loss_i,
  input  logic lol_en_i,
  input  logic pll_mode_i,
  input  logic ref_ok_i,
  input  logic lock_i,
  output logic hold_o,
  output logic trig_o,
  output logic rst_req_o
);
  import plc_pkg::*;

  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  seq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic ready;

  assign ready  = pll_mode_i ? (ref_ok_i & lock_i) : 1'b1;
  assign trig_o = (state_q == SEQ_IDLE) & loss_i & lol_en_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: if (trig_o) begin
        state_d = SEQ_HOLD;
        cnt_d   = '0;
      end
      SEQ_HOLD: begin
        if (cnt_q == LAST) state_d = SEQ_WAIT;
        else               cnt_d   = cnt_q + 1'b1;
      end
      SEQ_WAIT: if (ready) state_d = SEQ_IDLE;
      default:  state_d = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hold_o    = (state_q == SEQ_HOLD);
  assign rst_req_o = (state_q != SEQ_IDLE);

  assert_trig_starts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> rst_req_o && hold_o);
  assert_min_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_WAIT && $past(state_q) != SEQ_WAIT) |-> $past(cnt_q) == LAST);
  assert_hold_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> rst_req_o);
  assert_wait_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_WAIT && pll_mode_i && !(ref_ok_i && lock_i)) |=> rst_req_o);
endmodule

// File: rtl/plc_cause.sv
module plc_cause (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic trig_i,
  input  logic en_we_i,
  input  logic en_d_i,
  input  logic clr_i,
  output logic lol_en_o,
  output logic sticky_o
);
  logic en_q, sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (hold_i)  en_q <= 1'b0;
    else if (en_we_i) en_q <= en_d_i;
  end

  // survives the loss-of-lock request; only power-on or W1C clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sticky_q <= 1'b0;
    else if (trig_i) sticky_q <= 1'b1;
    else if (clr_i)  sticky_q <= 1'b0;
  end

  assign lol_en_o = en_q;
  assign sticky_o = sticky_q;

  assert_en_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !en_q);
  assert_sticky_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> sticky_q);
  assert_sticky_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sticky_q) |-> $past(clr_i));
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_mode_i,
  input  logic ref_ok_i,
  input  logic lock_evt_i,
  input  logic unlock_evt_i,
  input  logic mult_chg_i,
  input  logic stop_enter_i,
  input  logic stop_exit_i,
  input  logic stop_pll_off_i,
  input  logic lol_en_we_i,
  input  logic lol_en_i,
  input  logic lol_clr_i,
  output logic lock_o,
  output logic locks_o,
  output logic rst_req_o,
  output logic lol_flag_o
);
  logic hold, trig, loss, lol_en;

  plc_flags u_flags (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .hold_i         (hold),
    .lock_evt_i     (lock_evt_i),
    .unlock_evt_i   (unlock_evt_i),
    .mult_chg_i     (mult_chg_i),
    .stop_enter_i   (stop_enter_i),
    .stop_exit_i    (stop_exit_i),
    .stop_pll_off_i (stop_pll_off_i),
    .lock_o         (lock_o),
    .locks_o        (locks_o),
    .loss_o         (loss)
  );

  plc_rst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .loss_i     (loss),
    .lol_en_i   (lol_en),
    .pll_mode_i (pll_mode_i),
    .ref_ok_i   (ref_ok_i),
    .lock_i     (lock_o),
    .hold_o     (hold),
    .trig_o     (trig),
    .rst_req_o  (rst_req_o)
  );

  plc_cause u_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold),
    .trig_i   (trig),
    .en_we_i  (lol_en_we_i),
    .en_d_i   (lol_en_i),
    .clr_i    (lol_clr_i),
    .lol_en_o (lol_en),
    .sticky_o (lol_flag_o)
  );
endmodule

// File: tb/pll_lock_ctrl_test.sv
module pll_lock_ctrl_test;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pll_mode = 1'b1, ref_ok = 1'b1;
  logic lock_evt = 0, unlock_evt = 0, mult_chg = 0;
  logic stop_enter = 0, stop_exit = 0, stop_off = 0;
  logic en_we = 0, en_d = 0, lol_clr = 0;
  logic lock, locks, rst_req, lol_flag;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pll_lock_ctrl #(.HOLD_CYC(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pll_mode_i(pll_mode), .ref_ok_i(ref_ok),
    .lock_evt_i(lock_evt), .unlock_evt_i(unlock_evt), .mult_chg_i(mult_chg),
    .stop_enter_i(stop_enter), .stop_exit_i(stop_exit), .stop_pll_off_i(stop_off),
    .lol_en_we_i(en_we), .lol_en_i(en_d), .lol_clr_i(lol_clr),
    .lock_o(lock), .locks_o(locks), .rst_req_o(rst_req), .lol_flag_o(lol_flag)
  );

  typedef enum logic [2:0] {
    EV_NONE, EV_LOCK, EV_UNLK, EV_MFD, EV_STOFF, EV_STON, EV_SEXIT
  } ev_e;

  typedef struct packed {
    ev_e        ev;
    logic       lock;
    logic       locks;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{EV_UNLK,  1'b0, 1'b0, 4'd3}, // R3 unexpected loss
    '{EV_LOCK,  1'b1, 1'b0, 4'd3}, // R3 relock, LOCKS stays 0
    '{EV_LOCK,  1'b1, 1'b0, 4'd1}, // R1 repeat lock no change
    '{EV_MFD,   1'b0, 1'b0, 4'd2}, // R2 multiplier change
    '{EV_UNLK,  1'b0, 1'b0, 4'd2}, // R2 unlock while unlocked ignored
    '{EV_LOCK,  1'b1, 1'b1, 4'd2}, // R2 relock sets both
    '{EV_STOFF, 1'b0, 1'b0, 4'd4}, // R4 stop with PLL off
    '{EV_LOCK,  1'b0, 1'b0, 4'd4}, // R4 lock ignored in stop
    '{EV_SEXIT, 1'b0, 1'b0, 4'd4},
    '{EV_LOCK,  1'b1, 1'b1, 4'd4}, // R4 LOCKS restored to 1
    '{EV_UNLK,  1'b0, 1'b0, 4'd3},
    '{EV_LOCK,  1'b1, 1'b0, 4'd3},
    '{EV_STON,  1'b1, 1'b0, 4'd4}, // R4 stop with PLL on: no change
    '{EV_SEXIT, 1'b1, 1'b0, 4'd4}, // R4 exit outside stop-off: no change
    '{EV_STOFF, 1'b0, 1'b0, 4'd4},
    '{EV_SEXIT, 1'b0, 1'b0, 4'd4},
    '{EV_LOCK,  1'b1, 1'b0, 4'd4}, // R4 LOCKS restored to 0
    '{EV_MFD,   1'b0, 1'b0, 4'd2},
    '{EV_LOCK,  1'b1, 1'b1, 4'd2},
    '{EV_NONE,  1'b1, 1'b1, 4'd1}
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b @%0t", req, what, act, exp, $time);
    end
  endtask

  // called at a negedge; drives for one cycle, returns at the next negedge
  task automatic pulse(input ev_e ev);
    case (ev)
      EV_LOCK:  lock_evt = 1'b1;
      EV_UNLK:  unlock_evt = 1'b1;
      EV_MFD:   mult_chg = 1'b1;
      EV_STOFF: begin stop_enter = 1'b1; stop_off = 1'b1; end
      EV_STON:  begin stop_enter = 1'b1; stop_off = 1'b0; end
      EV_SEXIT: stop_exit = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    lock_evt = 0; unlock_evt = 0; mult_chg = 0; stop_enter = 0; stop_exit = 0;
  endtask

  task automatic write_en(input logic v);
    en_we = 1'b1; en_d = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // power-on bring-up, reference missing at first
    ref_ok = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    check("R8", "req after por", rst_req, 1'b1);
    check("R1", "lock after por", lock, 1'b0);
    check("R1", "locks after por", locks, 1'b0);
    check("R7", "flag after por", lol_flag, 1'b0);
    idle(3);
    pulse(EV_LOCK);
    check("R6", "lock ignored in hold", lock, 1'b0);
    idle(HOLD);
    pulse(EV_LOCK);
    check("R1", "first lock", lock, 1'b1);
    check("R1", "first locks", locks, 1'b1);
    idle(3);
    check("R9", "held without reference", rst_req, 1'b1);
    ref_ok = 1'b1;
    @(negedge clk);
    check("R9", "release on ref+lock", rst_req, 1'b0);

    // table walk, loss-of-lock reset disabled
    for (int i = 0; i < NV; i++) begin
      pulse(VECS[i].ev);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), "lock", lock, VECS[i].lock);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), "locks", locks, VECS[i].locks);
      check($sformatf("R5 vec%0d", i), "no req while disabled", rst_req, 1'b0);
    end

    // loss-of-lock reset in PLL mode
    write_en(1'b1);
    pulse(EV_UNLK);
    check("R5", "req on unexpected loss", rst_req, 1'b1);
    check("R7", "flag set", lol_flag, 1'b1);
    check("R6", "lock cleared", lock, 1'b0);
    idle(4);
    pulse(EV_LOCK);
    check("R6", "lock ignored in hold", lock, 1'b0);
    idle(HOLD - 5);
    check("R8", "still held", rst_req, 1'b1);
    idle(3);
    check("R9", "waits for lock", rst_req, 1'b1);
    pulse(EV_LOCK);
    check("R1", "lock after lol reset", lock, 1'b1);
    check("R1", "locks after lol reset", locks, 1'b1);
    @(negedge clk);
    check("R9", "released", rst_req, 1'b0);
    check("R7", "flag survives", lol_flag, 1'b1);
    pulse(EV_UNLK);
    check("R6", "enable cleared by request", rst_req, 1'b0);
    pulse(EV_LOCK);

    // non-PLL mode: exact hold length, trigger via multiplier change
    pll_mode = 1'b0;
    write_en(1'b1);
    pulse(EV_MFD);
    check("R5", "req on multiplier change", rst_req, 1'b1);
    idle(HOLD);
    check("R8", "held HOLD cycles", rst_req, 1'b1);
    @(negedge clk);
    check("R9", "release without lock", rst_req, 1'b0);
    pll_mode = 1'b1;

    // enable written back to 0
    pulse(EV_LOCK);
    write_en(1'b1);
    write_en(1'b0);
    pulse(EV_UNLK);
    check("R5", "no req with enable 0", rst_req, 1'b0);

    // sticky clear by write-one, then by power-on
    lol_clr = 1'b1;
    @(negedge clk);
    lol_clr = 1'b0;
    check("R7", "flag cleared by write", lol_flag, 1'b0);
    pulse(EV_LOCK);
    write_en(1'b1);
    pulse(EV_UNLK);
    check("R7", "flag set again", lol_flag, 1'b1);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R7", "flag cleared by por", lol_flag, 1'b0);
    check("R8", "req during por", rst_req, 1'b1);

    summary();
    $finish;
  end
endmodule